// File: doc/BRIEF.md
# Four-way set-associative read cache with least-recently-used replacement

The block is a read-only cache for 32-bit words. It holds eight sets of four ways, and each way holds one word. A requester presents a byte address. The cache splits the address into three fields: a byte offset, which it ignores, a set index and a tag. It then compares the tag against the four ways of the selected set at the same time. A hit returns the stored word one cycle after the request is accepted.

A miss raises a single-word fetch on the memory side. When the word arrives, the cache returns it and writes it into a way of the set. The cache chooses that way as follows:

- It prefers any way that holds nothing.
- If every way is occupied, it evicts the way with the oldest use stamp.

A running reference count provides the use stamps. The count advances once per accepted request, and the current count is copied into a way whenever that way is hit or filled.

Only one miss can be outstanding at a time. While it is outstanding, the cache refuses new requests.

Top module: `sa_rd_cache`

## Requirements
- R1: Address bits [1:0] are ignored, bits [4:2] select the set and bits [31:5] form the tag. The fetch address on `mem_addr_o` is the request address with bits [1:0] cleared.
- R2: A hit occurs when a way of the selected set is valid and its stored tag equals the request tag. One cycle after acceptance, the cache raises `rsp_valid_o` with `rsp_hit_o`=1 and the stored word, and it raises no fetch. At most one way of a set matches.
- R3: On a miss, `mem_req_o` rises one cycle after acceptance. It stays high, with a stable address, until `mem_valid_i` is sampled high. In the following cycle `rsp_valid_o` is 1, `rsp_hit_o` is 0 and `rsp_data_o` equals the sampled `mem_data_i`. No response appears while the fetch is pending.
- R4: A miss fills an invalid way of the set if one exists. When several ways are invalid, it fills the lowest-numbered one.
- R5: When all four ways of the set are valid, a miss replaces the way with the smallest use stamp. On a tie, the lowest-numbered way is replaced.
- R6: Every accepted request advances the reference count by one. A hit stamps the hitting way with the count at acceptance, and a fill stamps the filled way with the count at the acceptance of the missing request.
- R7: `req_ready_o` is low from the cycle after a missing request is accepted until the cycle after its fill. A request presented during that window is ignored: it produces no response and caches nothing.
- R8: Reset clears every valid bit and zeroes the reference count. It leaves `req_ready_o`=1, `rsp_valid_o`=0 and `mem_req_o`=0, so the first access to any address misses.
- R9: A fill or stamp update in one set leaves the contents of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | 32 | Byte address of the read |
| req_ready_o | output | 1 | Cache can accept a request this cycle |
| rsp_valid_o | output | 1 | Read data valid, one-cycle pulse per request |
| rsp_data_o | output | 32 | Read data |
| rsp_hit_o | output | 1 | Response came from a hit (1) or a fill (0) |
| mem_req_o | output | 1 | Word fetch pending toward memory |
| mem_addr_o | output | 32 | Word-aligned fetch address |
| mem_valid_i | input | 1 | Memory returns the fetched word |
| mem_data_i | input | 32 | Fetched word |

## Verification
The assertions assume three things about the inputs:
- Memory raises `mem_valid_i` only while `mem_req_o` is high, for exactly one cycle per fetch.
- A requester presents each request for a single cycle and keeps the address stable during it.
- Backing memory is read-only, so a word's value depends only on its address.

The bench respects all three. It drives a fixed function of the word address as memory content, answers each fetch once after a latency of one to three cycles, and drops `req_valid_i` after each acceptance edge. The only deliberate exception is a request offered while the cache is busy, which tests that such requests are ignored. Because memory is read-only, a stale or misplaced fill shows up as a wrong hit or miss flag, or as wrong data, on a later access.

// File: rtl/sa_rd_cache_pkg.sv
package sa_rd_cache_pkg;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_FETCH  = 1'b1
  } cache_state_e;

endpackage

// File: rtl/sa_way_store.sv
module sa_way_store #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 27,
  parameter int DATA_W   = 32,
  parameter int TS_W     = 16,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [SET_W-1:0]                  rd_set_i,
  output logic [NUM_WAYS-1:0]               rd_valid_o,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]    rd_tag_o,
  output logic [NUM_WAYS-1:0][DATA_W-1:0]   rd_data_o,
  output logic [NUM_WAYS-1:0][TS_W-1:0]     rd_ts_o,
  input  logic                              touch_i,
  input  logic [SET_W-1:0]                  touch_set_i,
  input  logic [WAY_W-1:0]                  touch_way_i,
  input  logic [TS_W-1:0]                   touch_ts_i,
  input  logic                              fill_i,
  input  logic [SET_W-1:0]                  fill_set_i,
  input  logic [WAY_W-1:0]                  fill_way_i,
  input  logic [TAG_W-1:0]                  fill_tag_i,
  input  logic [DATA_W-1:0]                 fill_data_i,
  input  logic [TS_W-1:0]                   fill_ts_i
);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    logic [NUM_SETS-1:0] valid_q;
    logic [TAG_W-1:0]    tag_q  [NUM_SETS];
    logic [DATA_W-1:0]   data_q [NUM_SETS];
    logic [TS_W-1:0]     ts_q   [NUM_SETS];

    logic fill_here, touch_here;
    assign fill_here  = fill_i  && (fill_way_i  == WAY_W'(g));
    assign touch_here = touch_i && (touch_way_i == WAY_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        for (int s = 0; s < NUM_SETS; s++) begin
          tag_q[s]  <= '0;
          data_q[s] <= '0;
          ts_q[s]   <= '0;
        end
      end else if (fill_here) begin
        valid_q[fill_set_i] <= 1'b1;
        tag_q[fill_set_i]   <= fill_tag_i;
        data_q[fill_set_i]  <= fill_data_i;
        ts_q[fill_set_i]    <= fill_ts_i;
      end else if (touch_here) begin
        ts_q[touch_set_i]   <= touch_ts_i;
      end
    end

    assign rd_valid_o[g] = valid_q[rd_set_i];
    assign rd_tag_o[g]   = tag_q[rd_set_i];
    assign rd_data_o[g]  = data_q[rd_set_i];
    assign rd_ts_o[g]    = ts_q[rd_set_i];
  end

endmodule

// File: rtl/sa_tag_match.sv
module sa_tag_match #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 27,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]               req_tag_i,
  output logic [NUM_WAYS-1:0]            hit_vec_o,
  output logic [WAY_W-1:0]               hit_way_o
);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == req_tag_i);
  end

  // encode; lowest index wins if the vector were ever not one-hot
  always_comb begin
    hit_way_o = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) hit_way_o = WAY_W'(i);
    end
  end

endmodule

// File: rtl/sa_victim_pick.sv
module sa_victim_pick #(
  parameter int NUM_WAYS = 4,
  parameter int TS_W     = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]           valid_i,
  input  logic [NUM_WAYS-1:0][TS_W-1:0] ts_i,
  output logic [WAY_W-1:0]              victim_o
);

  logic             have_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;
  logic [TS_W-1:0]  old_ts;

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!valid_i[i] && !have_free) begin
        have_free = 1'b1;
        free_way  = WAY_W'(i);
      end
    end
  end

  // strict less-than keeps the lower index on equal stamps
  always_comb begin
    old_way = '0;
    old_ts  = ts_i[0];
    for (int i = 1; i < NUM_WAYS; i++) begin
      if (ts_i[i] < old_ts) begin
        old_ts  = ts_i[i];
        old_way = WAY_W'(i);
      end
    end
  end

  assign victim_o = have_free ? free_way : old_way;

endmodule

// File: rtl/sa_rd_cache.sv
module sa_rd_cache
  import sa_rd_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int TS_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_hit_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;

  cache_state_e state_q;

  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic             unused_off;
  logic             accept;

  logic [NUM_WAYS-1:0]             rd_valid;
  logic [NUM_WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [NUM_WAYS-1:0][DATA_W-1:0] rd_data;
  logic [NUM_WAYS-1:0][TS_W-1:0]   rd_ts;
  logic [NUM_WAYS-1:0]             hit_vec;
  logic [WAY_W-1:0]                hit_way;
  logic [WAY_W-1:0]                victim_way;
  logic                            lookup_hit;

  logic [TS_W-1:0]  ref_cnt_q;
  logic [SET_W-1:0] pend_set_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic [WAY_W-1:0] pend_way_q;
  logic [TS_W-1:0]  pend_ts_q;

  logic              rsp_valid_q;
  logic              rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic fill;
  logic touch;

  assign req_set    = req_addr_i[OFF_W +: SET_W];
  assign req_tag    = req_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^req_addr_i[OFF_W-1:0];

  assign req_ready_o = (state_q == ST_LOOKUP);
  assign accept      = req_valid_i && req_ready_o;
  assign lookup_hit  = |hit_vec;
  assign touch       = accept && lookup_hit;
  assign fill        = (state_q == ST_FETCH) && mem_valid_i;

  sa_way_store #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .TAG_W    (TAG_W),
    .DATA_W   (DATA_W),
    .TS_W     (TS_W)
  ) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_set_i    (req_set),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_data_o   (rd_data),
    .rd_ts_o     (rd_ts),
    .touch_i     (touch),
    .touch_set_i (req_set),
    .touch_way_i (hit_way),
    .touch_ts_i  (ref_cnt_q),
    .fill_i      (fill),
    .fill_set_i  (pend_set_q),
    .fill_way_i  (pend_way_q),
    .fill_tag_i  (pend_tag_q),
    .fill_data_i (mem_data_i),
    .fill_ts_i   (pend_ts_q)
  );

  sa_tag_match #(
    .NUM_WAYS (NUM_WAYS),
    .TAG_W    (TAG_W)
  ) i_match (
    .valid_i   (rd_valid),
    .tag_i     (rd_tag),
    .req_tag_i (req_tag),
    .hit_vec_o (hit_vec),
    .hit_way_o (hit_way)
  );

  sa_victim_pick #(
    .NUM_WAYS (NUM_WAYS),
    .TS_W     (TS_W)
  ) i_victim (
    .valid_i  (rd_valid),
    .ts_i     (rd_ts),
    .victim_o (victim_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_LOOKUP;
      ref_cnt_q  <= '0;
      pend_set_q <= '0;
      pend_tag_q <= '0;
      pend_way_q <= '0;
      pend_ts_q  <= '0;
    end else begin
      if (accept) ref_cnt_q <= ref_cnt_q + TS_W'(1);
      unique case (state_q)
        ST_LOOKUP: begin
          if (accept && !lookup_hit) begin
            state_q    <= ST_FETCH;
            pend_set_q <= req_set;
            pend_tag_q <= req_tag;
            pend_way_q <= victim_way;
            pend_ts_q  <= ref_cnt_q;
          end
        end
        ST_FETCH: begin
          if (mem_valid_i) state_q <= ST_LOOKUP;
        end
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (touch) begin
        rsp_valid_q <= 1'b1;
        rsp_hit_q   <= 1'b1;
        rsp_data_q  <= rd_data[hit_way];
      end else if (fill) begin
        rsp_valid_q <= 1'b1;
        rsp_hit_q   <= 1'b0;
        rsp_data_q  <= mem_data_i;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_data_o  = rsp_data_q;
  assign mem_req_o   = (state_q == ST_FETCH);
  assign mem_addr_o  = {pend_tag_q, pend_set_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/sa_rd_cache_chk.sv
module sa_rd_cache_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_WAYS = 4,
  localparam int OFF_W   = $clog2(DATA_W / 8)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                rsp_valid_o,
  input logic                rsp_hit_o,
  input logic [DATA_W-1:0]   rsp_data_o,
  input logic                mem_req_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic                mem_valid_i,
  input logic [DATA_W-1:0]   mem_data_i,
  input logic [NUM_WAYS-1:0] hit_vec
);

  // R2
  one_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R2
  hit_from_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> $past(req_valid_i && req_ready_o));

  // R3
  fill_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> rsp_valid_o && !rsp_hit_o && (rsp_data_o == $past(mem_data_i)));

  // R3
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R1
  word_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  // R7
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> !req_ready_o);

endmodule

bind sa_rd_cache sa_rd_cache_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_WAYS (NUM_WAYS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_data_o  (rsp_data_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .mem_data_i  (mem_data_i),
  .hit_vec     (hit_vec)
);

// File: tb/test_sa_rd_cache.sv
`timescale 1ns/1ps
module test_sa_rd_cache;

  localparam int NS = 8;
  localparam int NW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_ready_o;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        rsp_hit_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_data_i = '0;

  sa_rd_cache i_sa_rd_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_hit_o   (rsp_hit_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_data_i  (mem_data_i)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  bit          mv  [NS][NW];
  int unsigned mt  [NS][NW];
  int unsigned mts [NS][NW];
  int unsigned mcount;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return w * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  function automatic logic [31:0] addr_of(input int s, input int t);
    return (32'(t) << 5) | (32'(s) << 2);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; mt[s][w] = 0; mts[s][w] = 0;
      end
    mcount = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    mem_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_clear();
    @(negedge clk_i);
    // R8
    chk(req_ready_o == 1'b1, "R8", "ready after reset", 32'(req_ready_o), 32'd1);
    chk(rsp_valid_o == 1'b0, "R8", "rsp_valid after reset", 32'(rsp_valid_o), 32'd0);
    chk(mem_req_o == 1'b0, "R8", "mem_req after reset", 32'(mem_req_o), 32'd0);
  endtask

  // one request; lat = memory latency in idle cycles; poke offers a request while busy
  task automatic access(input logic [31:0] a, input string rq, input int lat, input bit poke);
    int s;
    int unsigned t;
    int w;
    bit exp_hit;
    logic [31:0] exp_d;
    s = int'((a >> 2) & 32'd7);
    t = a >> 5;
    exp_d = mem_word(a);
    w = -1;
    for (int i = 0; i < NW; i++) if (w < 0 && mv[s][i] && mt[s][i] == t) w = i;
    exp_hit = (w >= 0);
    if (!exp_hit) begin
      for (int i = 0; i < NW; i++) if (w < 0 && !mv[s][i]) w = i;
      if (w < 0) begin
        w = 0;
        for (int i = 1; i < NW; i++) if (mts[s][i] < mts[s][w]) w = i;
      end
    end
    chk(req_ready_o == 1'b1, "R7", "ready before request", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (exp_hit) begin
      chk(rsp_valid_o && rsp_hit_o, rq, "hit response", {30'd0, rsp_valid_o, rsp_hit_o}, 32'd3);
      chk(rsp_data_o == exp_d, "R2", "hit data", rsp_data_o, exp_d);
      chk(!mem_req_o, "R2", "no fetch on hit", 32'(mem_req_o), 32'd0);
    end else begin
      chk(!rsp_valid_o && mem_req_o, rq, "miss starts fetch", {30'd0, rsp_valid_o, mem_req_o}, 32'd1);
      chk(mem_addr_o == {a[31:2], 2'b00}, "R1", "fetch address", mem_addr_o, {a[31:2], 2'b00});
      chk(!req_ready_o, "R7", "busy during fetch", 32'(req_ready_o), 32'd0);
      for (int k = 0; k < lat; k++) begin
        if (poke && k == 0) begin
          req_valid_i = 1'b1;
          req_addr_i  = a ^ 32'h20;
        end
        @(negedge clk_i);
        req_valid_i = 1'b0;
        chk(!rsp_valid_o, "R3", "no response while pending", 32'(rsp_valid_o), 32'd0);
        chk(mem_addr_o == {a[31:2], 2'b00}, "R3", "fetch address held", mem_addr_o, {a[31:2], 2'b00});
      end
      mem_valid_i = 1'b1;
      mem_data_i  = exp_d;
      @(negedge clk_i);
      mem_valid_i = 1'b0;
      mem_data_i  = '0;
      chk(rsp_valid_o && !rsp_hit_o, "R3", "fill response", {30'd0, rsp_valid_o, rsp_hit_o}, 32'd2);
      chk(rsp_data_o == exp_d, "R3", "fill data", rsp_data_o, exp_d);
      chk(req_ready_o, "R7", "ready after fill", 32'(req_ready_o), 32'd1);
      mv[s][w] = 1;
      mt[s][w] = t;
    end
    mts[s][w] = mcount;
    mcount++;
  endtask

  task automatic idle_cycle();
    @(negedge clk_i);
    chk(!rsp_valid_o, "R2", "single response pulse", 32'(rsp_valid_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    do_reset();

    // R8: first access misses
    access(addr_of(0, 1), "R8", 1, 0);
    // R4: remaining invalid ways fill in order
    access(addr_of(0, 2), "R4", 2, 0);
    access(addr_of(0, 3), "R4", 1, 0);
    access(addr_of(0, 4), "R4", 3, 0);
    idle_cycle();
    // R6: hits refresh stamps
    access(addr_of(0, 1), "R6", 1, 0);
    access(addr_of(0, 3), "R6", 1, 0);
    idle_cycle();
    // R5: oldest stamp evicted
    access(addr_of(0, 5), "R5", 1, 0);
    access(addr_of(0, 2), "R5", 2, 0);
    access(addr_of(0, 4), "R5", 1, 0);
    access(addr_of(0, 3), "R6", 1, 0);
    access(addr_of(0, 1), "R5", 1, 0);
    // R1: byte offset ignored
    access(addr_of(0, 3) | 32'd3, "R1", 1, 0);
    access(addr_of(0, 3) | 32'd1, "R1", 1, 0);
    idle_cycle();
    // R9: thrash set 5, set 0 keeps its lines
    for (int t = 1; t <= 6; t++) access(addr_of(5, t), "R9", 1, 0);
    access(addr_of(0, 3), "R9", 1, 0);
    access(addr_of(0, 4), "R9", 1, 0);
    // R7: request while busy is ignored, so its address still misses
    access(addr_of(2, 9), "R7", 3, 1);
    access(addr_of(2, 9) ^ 32'h20, "R7", 1, 0);
    idle_cycle();

    // mixed stream over a small tag space, two sets
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      access(addr_of(int'(lfsr[8]), int'(lfsr[15:12] % 6)) | {30'd0, lfsr[1:0]},
             "R5", 1 + int'(lfsr[21:20] % 3), lfsr[24]);
      if (lfsr[27:25] == 3'd0) idle_cycle();
    end

    // R8: reset mid-run empties the cache
    do_reset();
    access(addr_of(0, 3), "R8", 1, 0);
    access(addr_of(0, 3), "R2", 1, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule